// File: doc/BRIEF.md
# Programmable Output Logic Macrocell Bank

This block is the output stage of a sum-of-products logic device. For each of `N` cells it takes the OR of that cell's product terms and an output-enable product term. It also takes two static configuration bits per cell. From these it produces the pin value, the pin's drive enable and a feedback bit that returns to the AND array.

Each cell works either as a register or as a combinational path. In both modes the pin can be active-high or active-low. The cells share three global controls:

- an asynchronous clear term, which empties every flip-flop at once;
- a synchronous preset term, which sets every flip-flop at the next rising clock edge;
- a power-up reset, which clears every flip-flop at a clock edge.

Clear and preset act on the stored bit before the polarity inversion. As a result, the pin level after a clear depends on each cell's polarity bit.

The pad itself is modelled outside the block through a split interface. The block provides the value (`pin_out`) and the drive enable (`pin_oe`). It receives the level seen on the pad (`pin_in`), which an external source drives when the cell is not driving.

Top module: `olmc_bank`

## Requirements
- R1: With `cfg_comb[i]=0` (registered), the stored bit of cell i takes `sum_pt[i]` at each rising clock edge when no clear, preset or reset is active. `pin_out[i]` equals the stored bit XOR NOT `cfg_pol[i]`, so `cfg_pol[i]=1` is active-high and `cfg_pol[i]=0` inverts.
- R2: With `cfg_comb[i]=1` (combinational), `pin_out[i]` equals `sum_pt[i]` XOR NOT `cfg_pol[i]` in the same cycle, with no clock edge in between.
- R3: `pin_oe[i]` follows `oe_reg[i]` in registered mode and `oe_pt[i]` in combinational mode. A low `pin_oe[i]` means the pad is at high impedance.
- R4: In registered mode, `fb[i]` equals the stored bit and is unaffected by `pin_in[i]` and by the enable.
- R5: In combinational mode, `fb[i]` equals the pad level. That level is `pin_out[i]` while `pin_oe[i]=1` and `pin_in[i]` while `pin_oe[i]=0`.
- R6: `async_clr=1` clears every stored bit at once, before any clock edge, and holds them clear while it stays high.
- R7: `sync_pre=1` sets every stored bit at the next rising clock edge, whatever each cell's polarity.
- R8: When `async_clr` and `sync_pre` are both high, the clear wins and the stored bits are 0.
- R9: `rst=1` clears every stored bit at the rising edge and wins over `sync_pre`. After reset, a registered active-high pin reads 0 and a registered active-low pin reads 1.
- R10: Each cell follows its own `cfg_comb`/`cfg_pol` pair, so cells in different modes and polarities work side by side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the cell flip-flops |
| rst | input | 1 | Synchronous power-up reset, active high |
| async_clr | input | 1 | Global asynchronous clear product term |
| sync_pre | input | 1 | Global synchronous preset product term |
| sum_pt | input | N | Per-cell OR of the logic product terms |
| oe_pt | input | N | Per-cell enable product term (combinational mode) |
| oe_reg | input | N | Per-cell dedicated enable (registered mode) |
| pin_in | input | N | Level seen on each pad |
| cfg_pol | input | N | Polarity bit per cell: 1 active-high, 0 active-low |
| cfg_comb | input | N | Mode bit per cell: 1 combinational, 0 registered |
| pin_out | output | N | Value driven to each pad |
| pin_oe | output | N | Pad drive enable per cell |
| fb | output | N | Feedback bit per cell into the AND array |

## Verification
A stored bit that is wrong shows at the ports on the first sample after the faulty edge. In registered mode it appears on `fb` directly and on `pin_out` through the polarity inversion, so a wrong polarity and a wrong state give different signatures.

A clear that waits for a clock edge is caught by sampling `fb` half a nanosecond after `async_clr` rises, well before the next edge.

A feedback mux that picks the wrong source shows in combinational mode. There, a disabled pad with an external level that differs from `pin_out` makes `fb` disagree with the driven value within the same cycle.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef enum logic {
    SRC_REGISTERED    = 1'b0,
    SRC_COMBINATIONAL = 1'b1
  } olmc_src_e;

  // Polarity bit 1 keeps the level, 0 inverts it.
  function automatic logic apply_polarity(input logic value, input logic pol);
    return value ^ ~pol;
  endfunction

endpackage

// File: rtl/olmc_store.sv
module olmc_store #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         async_clr,
  input  logic         sync_pre,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or posedge async_clr) begin
      if (async_clr) begin
        q[i] <= 1'b0;
      end else if (rst) begin
        q[i] <= 1'b0;
      end else if (sync_pre) begin
        q[i] <= 1'b1;
      end else begin
        q[i] <= d[i];
      end
    end
  end

endmodule

// File: rtl/olmc_drive.sv
module olmc_drive
  import olmc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] stored,
  input  logic [N-1:0] sum_pt,
  input  logic [N-1:0] oe_pt,
  input  logic [N-1:0] oe_reg,
  input  logic [N-1:0] cfg_pol,
  input  logic [N-1:0] cfg_comb,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    olmc_src_e src;
    logic      picked;

    always_comb begin
      src = olmc_src_e'(cfg_comb[i]);
      if (src == SRC_COMBINATIONAL) begin
        picked    = sum_pt[i];
        pin_oe[i] = oe_pt[i];
      end else begin
        picked    = stored[i];
        pin_oe[i] = oe_reg[i];
      end
      pin_out[i] = apply_polarity(picked, cfg_pol[i]);
    end
  end

endmodule

// File: rtl/olmc_feedback.sv
module olmc_feedback
  import olmc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] stored,
  input  logic [N-1:0] pin_out,
  input  logic [N-1:0] pin_oe,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] cfg_comb,
  output logic [N-1:0] fb
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic pad_level;

    always_comb begin
      pad_level = pin_oe[i] ? pin_out[i] : pin_in[i];
      if (olmc_src_e'(cfg_comb[i]) == SRC_COMBINATIONAL) begin
        fb[i] = pad_level;
      end else begin
        fb[i] = stored[i];
      end
    end
  end

endmodule

// File: rtl/olmc_bank.sv
module olmc_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         async_clr,
  input  logic         sync_pre,
  input  logic [N-1:0] sum_pt,
  input  logic [N-1:0] oe_pt,
  input  logic [N-1:0] oe_reg,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] cfg_pol,
  input  logic [N-1:0] cfg_comb,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] fb
);

  logic [N-1:0] stored;

  olmc_store #(.N(N)) u_store (
    .clk       (clk),
    .rst       (rst),
    .async_clr (async_clr),
    .sync_pre  (sync_pre),
    .d         (sum_pt),
    .q         (stored)
  );

  olmc_drive #(.N(N)) u_drive (
    .stored   (stored),
    .sum_pt   (sum_pt),
    .oe_pt    (oe_pt),
    .oe_reg   (oe_reg),
    .cfg_pol  (cfg_pol),
    .cfg_comb (cfg_comb),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  olmc_feedback #(.N(N)) u_fb (
    .stored   (stored),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_in   (pin_in),
    .cfg_comb (cfg_comb),
    .fb       (fb)
  );

endmodule

// File: rtl/olmc_bank_chk.sv
module olmc_bank_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         async_clr,
  input logic         sync_pre,
  input logic [N-1:0] sum_pt,
  input logic [N-1:0] pin_in,
  input logic [N-1:0] cfg_pol,
  input logic [N-1:0] cfg_comb,
  input logic [N-1:0] pin_out,
  input logic [N-1:0] pin_oe,
  input logic [N-1:0] fb
);

  for (genvar i = 0; i < N; i++) begin : g_cell
    // R1
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!async_clr && !sync_pre && !cfg_comb[i]) |=>
        (async_clr || cfg_comb[i] || !$stable(cfg_comb[i]) || fb[i] == $past(sum_pt[i])));

    // R2
    comb_path_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_comb[i] |-> (pin_out[i] == (sum_pt[i] ^ ~cfg_pol[i])));

    // R5
    comb_pad_fb_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_comb[i] && !pin_oe[i]) |-> (fb[i] == pin_in[i]));

    // R6
    async_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (async_clr && !cfg_comb[i]) |-> !fb[i]);

    // R7
    preset_set_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_pre && !async_clr && !cfg_comb[i]) |=>
        (async_clr || cfg_comb[i] || fb[i]));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (async_clr)
      (rst && !cfg_comb[i]) |=> (cfg_comb[i] || !fb[i]));
  end

endmodule

bind olmc_bank olmc_bank_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .async_clr (async_clr),
  .sync_pre  (sync_pre),
  .sum_pt    (sum_pt),
  .pin_in    (pin_in),
  .cfg_pol   (cfg_pol),
  .cfg_comb  (cfg_comb),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .fb        (fb)
);

// File: tb/tb_olmc_bank.sv
`timescale 1ns/100ps
module tb_olmc_bank;
  localparam int N = 4;
  localparam int W = 3 * N;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1, async_clr = 1'b0, sync_pre = 1'b0;
  logic [N-1:0] sum_pt = '0, oe_pt = '0, oe_reg = '1, pin_in = '0;
  logic [N-1:0] cfg_pol = 4'b0101, cfg_comb = '0;
  logic [N-1:0] pin_out, pin_oe, fb;

  olmc_bank #(.N(N)) dut (
    .clk(clk), .rst(rst), .async_clr(async_clr), .sync_pre(sync_pre),
    .sum_pt(sum_pt), .oe_pt(oe_pt), .oe_reg(oe_reg), .pin_in(pin_in),
    .cfg_pol(cfg_pol), .cfg_comb(cfg_comb),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  // Staged settings, applied to the DUT by the driver.
  logic [N-1:0] nx_oe_pt = '0, nx_oe_reg = '1, nx_pin_in = '0;
  logic [N-1:0] nx_pol = 4'b0101, nx_comb = '0;

  logic [N-1:0] model_q = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [W-1:0] predict();
    logic [N-1:0] o, e, f;
    for (int i = 0; i < N; i++) begin
      logic sel;
      sel  = cfg_comb[i] ? sum_pt[i] : model_q[i];
      o[i] = sel ^ ~cfg_pol[i];
      e[i] = cfg_comb[i] ? oe_pt[i] : oe_reg[i];
      f[i] = cfg_comb[i] ? (e[i] ? o[i] : pin_in[i]) : model_q[i];
    end
    return {o, e, f};
  endfunction

  task automatic step(input logic [N-1:0] s, input logic a, input logic p,
                      input logic r, input string tag);
    @(negedge clk);
    #1;
    sum_pt = s; async_clr = a; sync_pre = p; rst = r;
    oe_pt = nx_oe_pt; oe_reg = nx_oe_reg; pin_in = nx_pin_in;
    cfg_pol = nx_pol; cfg_comb = nx_comb;
    for (int i = 0; i < N; i++)
      model_q[i] = (r || a) ? 1'b0 : (p ? 1'b1 : s[i]);
    exp_q.push_back(predict());
    tag_q.push_back(tag);
  endtask

  // Scoreboard monitor: compares results between clock edges.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({pin_out, pin_oe, fb} !== e) begin
        errors++;
        $display("FAIL %s: {out,oe,fb} got %h expected %h", t, {pin_out, pin_oe, fb}, e);
      end
    end
  end

  initial begin
    // R9: power-up reset, registered cells, mixed polarity
    step(4'b1111, 1'b0, 1'b0, 1'b1, "R9 power-up reset");
    step(4'b1111, 1'b0, 1'b0, 1'b1, "R9 reset held");
    // R1: registered loads, both polarities
    step(4'b1010, 1'b0, 1'b0, 1'b0, "R1 load 1010");
    step(4'b0110, 1'b0, 1'b0, 1'b0, "R1 load 0110");
    step(4'b1111, 1'b0, 1'b0, 1'b0, "R1 load 1111");
    step(4'b0000, 1'b0, 1'b0, 1'b0, "R1 load 0000");
    // R4/R3: registered feedback ignores pad, dedicated enable
    nx_pin_in = 4'b1111; nx_oe_reg = 4'b0011;
    step(4'b1001, 1'b0, 1'b0, 1'b0, "R4 fb from register");
    step(4'b0110, 1'b0, 1'b0, 1'b0, "R3 R4 oe_reg and fb");
    // R7: preset
    step(4'b0000, 1'b0, 1'b1, 1'b0, "R7 preset");
    step(4'b0000, 1'b0, 1'b0, 1'b0, "R1 after preset");
    // R8: clear beats preset
    step(4'b1111, 1'b0, 1'b0, 1'b0, "R1 load before R8");
    step(4'b0000, 1'b1, 1'b1, 1'b0, "R8 clear over preset");
    step(4'b1111, 1'b0, 1'b0, 1'b0, "R1 after clear");
    // R6: clear acts before any edge
    step(4'b1111, 1'b1, 1'b0, 1'b0, "R6 clear held");
    #0.5;
    checks++;
    if (fb !== 4'b0000) begin
      errors++;
      $display("FAIL R6 immediate clear: fb got %b expected 0000", fb);
    end
    step(4'b1111, 1'b0, 1'b0, 1'b0, "R1 reload");
    // R9: reset wins over preset
    step(4'b1111, 1'b0, 1'b1, 1'b1, "R9 reset over preset");
    // R2/R3/R5: all combinational
    nx_comb = 4'b1111; nx_pol = 4'b1100; nx_oe_pt = 4'b1010; nx_pin_in = 4'b0110;
    step(4'b0011, 1'b0, 1'b0, 1'b0, "R2 R5 comb pattern a");
    step(4'b1101, 1'b0, 1'b0, 1'b0, "R2 R5 comb pattern b");
    nx_oe_pt = 4'b0101; nx_pin_in = 4'b1001;
    step(4'b0110, 1'b0, 1'b0, 1'b0, "R3 R5 comb enable swap");
    nx_oe_pt = 4'b0000; nx_pin_in = 4'b1010;
    step(4'b1111, 1'b0, 1'b0, 1'b0, "R5 pads all external");
    // R10: mixed modes and polarities
    nx_comb = 4'b1100; nx_pol = 4'b1010; nx_oe_pt = 4'b0100; nx_oe_reg = 4'b0011;
    nx_pin_in = 4'b1000;
    step(4'b0101, 1'b0, 1'b0, 1'b0, "R10 mixed a");
    step(4'b1010, 1'b0, 1'b0, 1'b0, "R10 mixed b");
    step(4'b0011, 1'b0, 1'b1, 1'b0, "R10 R7 mixed preset");
    step(4'b0000, 1'b0, 1'b0, 1'b1, "R10 R9 mixed reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule